// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and decides when an exception is actually taken. Any of the first four stages may flag one or more cause bits against the instruction it currently holds. Those flags are not acted on when they appear. They are ORed into a small cause vector that travels with the instruction. The decision is made only when the instruction occupies the writeback stage, before it can update architectural state. Because of this, exceptions are always serviced in program order, however early a younger instruction raised its own.

When the instruction in writeback carries a non-empty cause vector, its write is blocked and a one-cycle trap strobe is raised. The strobe carries that instruction's PC and an encoded cause. A flush is signalled in the same cycle, and on the following clock edge every stage is emptied, so the faulting instruction and everything younger can be restarted after the trap routine. Instructions older than the faulting one have already retired normally. A stall freezes the whole pipeline, including the cause vectors.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, every stage is empty (`stageValid` = 0) and `wbEnable`, `flush` and `trapValid` are low.
- R2: An instruction accepted through `fetchValid`/`fetchPc` at a clock edge, with no stall and no cause raised, occupies writeback after four further edges. During that cycle `wbEnable` is high and `retirePc` equals its PC.
- R3: Cause bits raised against an instruction in any stage accumulate in its vector. `raiseBits[s*4 + c]` raises cause c for stage s (s: 0 fetch, 1 decode, 2 execute, 3 memory; c: 0 fetch fault, 1 illegal opcode, 2 arithmetic overflow, 3 memory fault).
- R4: An exception is acted on only in the cycle its instruction occupies writeback. No trap or flush appears while that instruction is in an earlier stage.
- R5: Exceptions are serviced in program order. An older instruction's exception is trapped even when a younger instruction raised its exception at an earlier clock cycle.
- R6: `wbEnable` stays low for the faulting instruction and for every younger instruction. Every older instruction retires with `wbEnable` high.
- R7: `trapValid` is high for exactly one cycle per taken exception. In that cycle `trapPc` is the faulting instruction's PC and `trapCause` is the index of the lowest-numbered set bit of its cause vector.
- R8: `flush` is high in the trap cycle. At the next edge every stage is cleared, including any instruction offered on `fetchValid` at that edge.
- R9: While `stall` is high, every stage's contents (valid, PC, cause vector) are held, raised cause bits are ignored, and `wbEnable` and `trapValid` are low. A trap pending in writeback is taken once the stall drops.
- R10: Cause bits raised against a stage that holds no valid instruction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes all stages for this cycle |
| fetchValid | input | 1 | A new instruction enters the fetch stage at this edge |
| fetchPc | input | 32 | PC of the entering instruction |
| raiseBits | input | 16 | Cause pulses, 4 bits per stage for fetch..memory |
| stageValid | output | 5 | Occupancy of stages fetch (bit 0) to writeback (bit 4) |
| wbEnable | output | 1 | Write gate for the instruction in writeback |
| retirePc | output | 32 | PC of the instruction in writeback |
| flush | output | 1 | Squash of all stages at the next edge |
| trapValid | output | 1 | One-cycle trap redirect strobe |
| trapPc | output | 32 | PC of the faulting instruction during the strobe |
| trapCause | output | 2 | Encoded cause during the strobe |

## Verification
A cause bit lost or smeared onto the wrong instruction while moving down the stages shows at the ports exactly when that instruction reaches writeback, at most four cycles after it was raised. It appears either as a write that should have been blocked or as a trap with the wrong PC or code. A stage left valid after a flush shows on `stageValid` on the very next cycle. It would then also show as a spurious retire within four cycles. Sweeping every raising stage against every cause bit, and every multi-bit cause combination, ties each such fault to one cycle-exact expected trap.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;

  localparam int DEF_STAGES = 5;
  localparam int DEF_CAUSE_W = 4;
  localparam int DEF_PC_W = 32;

  // strobes from the commit decision to the stage registers
  typedef struct packed {
    logic advance;
    logic flush;
  } pipeStrobes_t;

endpackage

// File: rtl/exc_commit_pipe.sv
module exc_commit_pipe
  import exc_commit_pkg::*;
#(
  parameter int NUM_STAGES = DEF_STAGES,
  parameter int CAUSE_W = DEF_CAUSE_W,
  parameter int PC_W = DEF_PC_W,
  localparam int RAISE_W = (NUM_STAGES - 1) * CAUSE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pipeStrobes_t          strobes,
  input  logic                  fetchValid,
  input  logic [PC_W-1:0]       fetchPc,
  input  logic [RAISE_W-1:0]    raiseBits,
  output logic [NUM_STAGES-1:0] stageValid,
  output logic [PC_W-1:0]       wbPc,
  output logic [CAUSE_W-1:0]    wbCause
);

  localparam int WB = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0]              validQ;
  logic [NUM_STAGES-1:0][PC_W-1:0]    pcQ;
  logic [NUM_STAGES-1:0][CAUSE_W-1:0] causeQ;
  logic [NUM_STAGES-1:0][CAUSE_W-1:0] causeNext;

  // vector entering each stage: previous vector plus that stage's pulses,
  // masked when the previous stage is empty
  assign causeNext[0] = '0;
  for (genvar s = 1; s < NUM_STAGES; s++) begin : g_cause
    assign causeNext[s] = validQ[s-1]
                        ? (causeQ[s-1] | raiseBits[(s-1)*CAUSE_W +: CAUSE_W])
                        : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      pcQ    <= '0;
      causeQ <= '0;
    end else if (strobes.flush) begin
      validQ <= '0;
      causeQ <= '0;
    end else if (strobes.advance) begin
      validQ <= {validQ[NUM_STAGES-2:0], fetchValid};
      pcQ    <= {pcQ[NUM_STAGES-2:0], fetchPc};
      causeQ <= causeNext;
    end
  end

  assign stageValid = validQ;
  assign wbPc       = pcQ[WB];
  assign wbCause    = causeQ[WB];

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (validQ == '0) && (causeQ == '0));

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.flush) |=>
      $stable(validQ) && $stable(pcQ) && $stable(causeQ));

  a_r4_flush_needs_fault: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |-> validQ[WB] && (causeQ[WB] != '0));

endmodule

// File: rtl/exc_commit_ctl.sv
module exc_commit_ctl
  import exc_commit_pkg::*;
#(
  parameter int CAUSE_W = DEF_CAUSE_W,
  localparam int CODE_W = (CAUSE_W > 1) ? $clog2(CAUSE_W) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic               wbValid,
  input  logic [CAUSE_W-1:0] wbCause,
  output pipeStrobes_t       strobes,
  output logic               wbEnable,
  output logic               trapValid,
  output logic [CODE_W-1:0]  trapCause
);

  logic              hasFault;
  logic [CODE_W-1:0] codeRaw;

  always_comb begin
    hasFault = |wbCause;
    // lowest set bit wins: scan downward so the last hit is the smallest
    codeRaw = '0;
    for (int i = CAUSE_W - 1; i >= 0; i--) begin
      if (wbCause[i]) codeRaw = CODE_W'(i);
    end
    strobes.advance = !stall;
    strobes.flush   = wbValid && hasFault && !stall;
    wbEnable        = wbValid && !hasFault && !stall;
    trapValid       = strobes.flush;
    trapCause       = trapValid ? codeRaw : '0;
  end

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);

  a_r6_no_write_in_trap: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wbEnable, trapValid}));

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_commit_pkg::*;
#(
  parameter int NUM_STAGES = DEF_STAGES,
  parameter int CAUSE_W = DEF_CAUSE_W,
  parameter int PC_W = DEF_PC_W,
  localparam int RAISE_W = (NUM_STAGES - 1) * CAUSE_W,
  localparam int CODE_W = (CAUSE_W > 1) ? $clog2(CAUSE_W) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stall,
  input  logic                  fetchValid,
  input  logic [PC_W-1:0]       fetchPc,
  input  logic [RAISE_W-1:0]    raiseBits,
  output logic [NUM_STAGES-1:0] stageValid,
  output logic                  wbEnable,
  output logic [PC_W-1:0]       retirePc,
  output logic                  flush,
  output logic                  trapValid,
  output logic [PC_W-1:0]       trapPc,
  output logic [CODE_W-1:0]     trapCause
);

  pipeStrobes_t      strobes;
  logic [CAUSE_W-1:0] wbCause;

  exc_commit_pipe #(
    .NUM_STAGES(NUM_STAGES),
    .CAUSE_W(CAUSE_W),
    .PC_W(PC_W)
  ) i_pipe (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .fetchValid(fetchValid),
    .fetchPc(fetchPc),
    .raiseBits(raiseBits),
    .stageValid(stageValid),
    .wbPc(retirePc),
    .wbCause(wbCause)
  );

  exc_commit_ctl #(
    .CAUSE_W(CAUSE_W)
  ) i_ctl (
    .clk(clk),
    .rstN(rstN),
    .stall(stall),
    .wbValid(stageValid[NUM_STAGES-1]),
    .wbCause(wbCause),
    .strobes(strobes),
    .wbEnable(wbEnable),
    .trapValid(trapValid),
    .trapCause(trapCause)
  );

  assign flush  = strobes.flush;
  assign trapPc = trapValid ? retirePc : '0;

endmodule

// File: tb/test_exc_commit_ctrl.sv
`timescale 1ns/1ps
module test_exc_commit_ctrl;

  localparam int NI = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [15:0] raiseBits = '0;
  logic [4:0]  stageValid;
  logic        wbEnable;
  logic [31:0] retirePc;
  logic        flush;
  logic        trapValid;
  logic [31:0] trapPc;
  logic [1:0]  trapCause;

  int checks = 0;
  int errors = 0;
  logic [3:0] maskArr [NI][4];
  int scen = 0;

  exc_commit_ctrl i_exc_commit_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .fetchValid(fetchValid),
    .fetchPc(fetchPc), .raiseBits(raiseBits), .stageValid(stageValid),
    .wbEnable(wbEnable), .retirePc(retirePc), .flush(flush),
    .trapValid(trapValid), .trapPc(trapPc), .trapCause(trapCause)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s scen %0d t=%0t actual=%0h expected=%0h", req, scen, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] pcOf(input int j);
    return 32'h1000 + 32'(scen) * 32'h100 + 32'(j) * 4;
  endfunction

  task automatic doReset();
    rstN = 1'b0; stall = 1'b0; fetchValid = 1'b0; raiseBits = '0;
    repeat (2) @(negedge clk);
    chk("R1 valid", 64'(stageValid), 0);
    chk("R1 outs", 64'({wbEnable, flush, trapValid}), 0);
    rstN = 1'b1;
  endtask

  task automatic clearMasks();
    for (int j = 0; j < NI; j++)
      for (int s = 0; s < 4; s++) maskArr[j][s] = '0;
  endtask

  // one stream of NI instructions, one per cycle, masks from maskArr
  task automatic runStream();
    int f;
    logic [3:0] orMask;
    int code;
    f = -1;
    for (int j = NI - 1; j >= 0; j--) begin
      orMask = maskArr[j][0] | maskArr[j][1] | maskArr[j][2] | maskArr[j][3];
      if (orMask != 0) f = j;
    end
    code = 0;
    if (f >= 0) begin
      orMask = maskArr[f][0] | maskArr[f][1] | maskArr[f][2] | maskArr[f][3];
      for (int c = 3; c >= 0; c--) if (orMask[c]) code = c;
    end
    doReset();
    chk("R1 after release", 64'({stageValid, wbEnable, trapValid}), 0);
    // inputs for edge 0
    fetchValid = 1'b1; fetchPc = pcOf(0); raiseBits = 16'hFFFF;
    for (int e = 0; e <= NI + 5; e++) begin
      int jw;
      @(negedge clk);
      jw = e - 4;
      if (f >= 0 && jw == f) begin
        chk("R7 trap strobe", 64'(trapValid), 1);
        chk("R7 trap pc", 64'(trapPc), 64'(pcOf(f)));
        chk("R7 trap cause", 64'(trapCause), 64'(code));
        chk("R6 faulting no write", 64'(wbEnable), 0);
        chk("R8 flush with trap", 64'(flush), 1);
      end else if (jw >= 0 && jw < NI && (f < 0 || jw < f)) begin
        chk("R2 retire", 64'(wbEnable), 1);
        chk("R2 retire pc", 64'(retirePc), 64'(pcOf(jw)));
        chk("R5 no early trap", 64'({trapValid, flush}), 0);
      end else begin
        chk("R6 R4 quiet", 64'({wbEnable, trapValid, flush}), 0);
      end
      if (f >= 0 && e == f + 5) chk("R8 all cleared", 64'(stageValid), 0);
      // drive for edge e+1
      fetchValid = ((e + 1) < NI) && (f < 0 || (e + 1) <= f + 5);
      fetchPc = pcOf(e + 1);
      for (int s = 0; s < 4; s++) begin
        int j;
        j = e - s;
        // R10: stages with no instruction see all cause bits raised
        if (j >= 0 && j < NI && (f < 0 || j <= f + 5)) raiseBits[s*4 +: 4] = maskArr[j][s];
        else raiseBits[s*4 +: 4] = 4'hF;
      end
    end
    fetchValid = 1'b0; raiseBits = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 R10: clean stream, empty stages raising everything
    clearMasks();
    runStream();
    scen++;
    // R3 R4 R5: every raising stage against every cause bit on instr 2,
    // younger instr 3 raises in fetch before instr 2's late flag
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        clearMasks();
        maskArr[2][s] = 4'(1 << c);
        maskArr[3][0] = 4'h1;
        runStream();
        scen++;
      end
    end
    // R3 R7: all multi-bit vectors, bit k raised in stage k
    for (int m = 1; m < 16; m++) begin
      clearMasks();
      for (int k = 0; k < 4; k++) maskArr[0][k] = 4'(m) & 4'(1 << k);
      runStream();
      scen++;
    end
    // R5: two faulting instructions, older one trapped
    clearMasks();
    maskArr[4][3] = 4'h4;
    maskArr[5][0] = 4'h2;
    maskArr[6][1] = 4'h8;
    runStream();
    scen++;

    // R9: raise during stall is ignored, contents held
    doReset();
    fetchValid = 1'b1; fetchPc = 32'h2000;
    @(negedge clk);
    fetchValid = 1'b0; raiseBits = '0;
    @(negedge clk);
    stall = 1'b1; raiseBits = 16'h00F0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", 64'(stageValid), 64'h02);
      chk("R9 quiet", 64'({wbEnable, trapValid}), 0);
    end
    stall = 1'b0; raiseBits = '0;
    repeat (3) @(negedge clk);
    chk("R9 ignored raise retires", 64'({wbEnable, trapValid}), 64'h2);
    chk("R9 retire pc", 64'(retirePc), 64'h2000);

    // R9: trap pending in writeback waits for stall release
    doReset();
    fetchValid = 1'b1; fetchPc = 32'h3000;
    @(negedge clk);
    fetchValid = 1'b0; raiseBits = 16'h0008;
    @(negedge clk);
    raiseBits = '0;
    repeat (3) @(negedge clk);
    stall = 1'b1;
    #1;
    chk("R9 stalled trap held", 64'({trapValid, flush, wbEnable}), 0);
    @(negedge clk);
    chk("R9 W held", 64'(stageValid), 64'h10);
    stall = 1'b0;
    #1;
    chk("R9 trap after stall", 64'(trapValid), 1);
    chk("R7 cause after stall", 64'(trapCause), 3);
    chk("R7 pc after stall", 64'(trapPc), 64'h3000);
    @(negedge clk);
    chk("R8 cleared after stall trap", 64'(stageValid), 0);
    chk("R7 single strobe", 64'(trapValid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule